// File: doc/BRIEF.md
# DisplayPort AUX Request Sequencer with I2C Bridge

This block serves AUX request transactions, one at a time, and answers each with a two-bit reply code. A request holds a command, an address, a byte count and a write buffer of up to 16 bytes. Native commands become single-byte accesses on an internal register port that spans a 20-bit (1 MiB) address space. I2C-over-AUX commands become operations on a byte-level I2C master command port: start (with 7-bit address and direction), one-byte transfer, and stop.

Requests with the middle-of-transaction flag leave the I2C bus open when they finish. The block keeps the command and 7-bit address of the last such request. A later MOT request with the same pair continues on the open bus without a new start. A change in either one closes the bus and opens it again. A plain I2C request always closes any open transaction first and always ends with its own stop. The AUX line coding and I2C bit timing belong to other blocks.

A caller presents a request while `req_ready` is high. Each sub-port command is held until its one-cycle done pulse. The reply comes with a one-cycle `rep_valid`, and for reads the returned bytes sit in `rep_rdata`.

Top module: `dpx_xact_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `rep_valid`, `reg_req` and `i2c_cmd_valid` are 0.
- R2: The valid command codes are 4'h8 native write, 4'h9 native read, 4'h0 I2C write, 4'h1 I2C read, 4'h4 I2C write with MOT and 4'h5 I2C read with MOT. Any other code, or a length above 16, gets reply 2'b01 (AUX NACK) with no register or I2C activity.
- R3: A native request of N bytes makes N register accesses at addresses A, A+1, and so on. Read byte i is returned in `rep_rdata[8i+7:8i]`, and write byte i is taken from the same lanes of `req_wdata`. When all N accesses succeed, the reply is 2'b00 (ACK).
- R4: If a native byte access returns `reg_err`, the block makes no further access and replies 2'b01.
- R5: A native request with length 0 replies 2'b01 and makes no register access.
- R6: A plain I2C request (op codes: start 2'd0, transfer 2'd1, stop 2'd2) sends a stop first if the bus is open. It then sends a start, the bytes and a final stop. If all succeed, the reply is 2'b00.
- R7: If a plain I2C start is not acknowledged, the reply is 2'b10 (I2C NACK) and no transfer or stop follows.
- R8: If a byte fails during a plain I2C request, the block transfers no more bytes, sends a stop and replies 2'b10.
- R9: A MOT request on an idle bus sends a start. If the start is not acknowledged, the reply is 2'b10 and the bus stays idle, so the next request sends no stop first.
- R10: A MOT request on an open bus whose command and 7-bit address both match the last MOT request sends no start, transfers its bytes and replies 2'b00.
- R11: A MOT request on an open bus whose command or address differs sends a stop and then a start before its bytes. A start is never issued while the bus is open.
- R12: If a byte fails during a MOT request, the block sends a stop and replies 2'b10. A MOT request with length 0 sends only a start, replies 2'b00 and leaves the bus open.
- R13: `rep_valid` lasts exactly one cycle, and `req_ready` is low from the accept cycle through the reply cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register address, or I2C address in bits 6:0 |
| req_len | input | 5 | Byte count, 0 to 16 |
| req_wdata | input | 128 | Write bytes, byte i in bits 8i+7:8i |
| rep_valid | output | 1 | Reply pulse |
| rep_code | output | 2 | Reply code |
| rep_rdata | output | 128 | Read bytes |
| reg_req | output | 1 | Register access request, held until done |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 20 | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_done | input | 1 | Register access complete |
| reg_err | input | 1 | Register access failed, qualified by done |
| reg_rdata | input | 8 | Register read byte |
| i2c_cmd_valid | output | 1 | I2C operation request, held until done |
| i2c_cmd_op | output | 2 | Operation code |
| i2c_cmd_addr | output | 7 | Target address for start |
| i2c_cmd_rd | output | 1 | Direction, 1 for read |
| i2c_cmd_wdata | output | 8 | Byte to send |
| i2c_cmd_done | input | 1 | Operation complete |
| i2c_cmd_nack | input | 1 | Operation not acknowledged, qualified by done |
| i2c_cmd_rdata | input | 8 | Byte received |

## Verification
A wrong open-bus flag or a stale last-address record does not show up in the request that corrupts it. It shows up in the next MOT request, as a missing or extra stop/start pair, so the bench chains requests and counts I2C operations across them. A wrong byte index or a failed abort shows up at once as an extra or out-of-place register access, or in the wrong reply lane, before that request's reply. A reply code that is taken from the wrong path is seen in the same reply.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  typedef enum logic [1:0] {
    REP_ACK      = 2'b00,
    REP_AUX_NACK = 2'b01,
    REP_I2C_NACK = 2'b10
  } rep_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_XFER  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef enum logic [1:0] {
    CLS_BAD,
    CLS_NATIVE,
    CLS_PLAIN,
    CLS_MOT
  } cls_e;

  // Bit 3 marks native; bit 2 marks MOT on I2C codes; bit 0 is read.
  function automatic cls_e cmd_class(input logic [3:0] c);
    case (c)
      4'h8, 4'h9: return CLS_NATIVE;
      4'h0, 4'h1: return CLS_PLAIN;
      4'h4, 4'h5: return CLS_MOT;
      default:    return CLS_BAD;
    endcase
  endfunction

endpackage

// File: rtl/dpx_cmd_decode.sv
module dpx_cmd_decode
  import dpx_pkg::*;
(
  input  logic [3:0] cmd,
  output cls_e       cls,
  output logic       rd,
  output logic       bad
);
  always_comb begin
    cls = cmd_class(cmd);
    rd  = cmd[0];
    bad = (cls == CLS_BAD);
  end
endmodule

// File: rtl/dpx_i2c_track.sv
module dpx_i2c_track #(
  parameter int AW = 7,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_set,
  input  logic          open_clr,
  input  logic          store,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] cur_cmd,
  output logic          bus_open,
  output logic          differs
);
  logic [AW-1:0] last_addr;
  logic [CW-1:0] last_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_open  <= 1'b0;
      last_addr <= '0;
      last_cmd  <= '0;
    end else begin
      if (open_set)      bus_open <= 1'b1;
      else if (open_clr) bus_open <= 1'b0;
      if (store) begin
        last_addr <= cur_addr;
        last_cmd  <= cur_cmd;
      end
    end
  end

  assign differs = (cur_addr != last_addr) || (cur_cmd != last_cmd);
endmodule

// File: rtl/dpx_byte_buf.sv
module dpx_byte_buf #(
  parameter int NB = 16,
  parameter int IW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_byte,
  output logic [NB*8-1:0] data
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                      lane_q <= '0;
      else if (wr_en && wr_idx == IW'(g))    lane_q <= wr_byte;
    end
    assign data[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/dpx_xact_seq.sv
module dpx_xact_seq
  import dpx_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW = 7,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int BUF_W = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_W-1:0]  req_wdata,
  output logic              rep_valid,
  output logic [1:0]        rep_code,
  output logic [BUF_W-1:0]  rep_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_done,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_cmd_valid,
  output logic [1:0]        i2c_cmd_op,
  output logic [I2C_AW-1:0] i2c_cmd_addr,
  output logic              i2c_cmd_rd,
  output logic [7:0]        i2c_cmd_wdata,
  input  logic              i2c_cmd_done,
  input  logic              i2c_cmd_nack,
  input  logic [7:0]        i2c_cmd_rdata
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISPATCH, ST_NAT, ST_PRE_STOP,
    ST_START, ST_XFER, ST_POST_STOP, ST_REPLY
  } st_e;

  function automatic logic [7:0] pick_byte(input logic [BUF_W-1:0] b,
                                           input logic [LEN_W-1:0] i);
    return b[i*8 +: 8];
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [LEN_W-1:0] i);
    return base + ADDR_W'(i);
  endfunction

  st_e               st;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [BUF_W-1:0]  wdata_q;
  logic [LEN_W-1:0]  idx_q;
  rep_e              code_q;

  cls_e cls;
  logic is_rd, is_bad;
  logic bus_open, differs;

  // Named internal events, used by logic and by the bound checker.
  logic accept, ev_bad, byte_last, ev_start_ok, ev_stop_done;
  logic ev_continue, is_mot, len_over, len_zero;
  logic buf_we;
  logic [7:0] buf_byte;

  dpx_cmd_decode u_dec (
    .cmd(cmd_q), .cls(cls), .rd(is_rd), .bad(is_bad)
  );

  assign accept       = (st == ST_IDLE) && req_valid;
  assign is_mot       = (cls == CLS_MOT);
  assign len_over     = (len_q > LEN_W'(MAX_LEN));
  assign len_zero     = (len_q == '0);
  assign ev_bad       = (st == ST_DISPATCH) && (is_bad || len_over);
  assign byte_last    = (idx_q == len_q - 1'b1);
  assign ev_start_ok  = (st == ST_START) && i2c_cmd_done && !i2c_cmd_nack;
  assign ev_stop_done = ((st == ST_PRE_STOP) || (st == ST_POST_STOP)) && i2c_cmd_done;
  assign ev_continue  = (st == ST_DISPATCH) && !ev_bad && is_mot && bus_open && !differs;

  dpx_i2c_track #(.AW(I2C_AW), .CW(4)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_set (ev_start_ok),
    .open_clr (ev_stop_done),
    .store    (is_mot && (ev_start_ok || ev_continue)),
    .cur_addr (addr_q[I2C_AW-1:0]),
    .cur_cmd  (cmd_q),
    .bus_open (bus_open),
    .differs  (differs)
  );

  always_comb begin
    buf_we   = 1'b0;
    buf_byte = reg_rdata;
    if (st == ST_NAT && reg_done && !reg_err && is_rd) begin
      buf_we = 1'b1;
    end else if (st == ST_XFER && i2c_cmd_done && !i2c_cmd_nack && is_rd) begin
      buf_we   = 1'b1;
      buf_byte = i2c_cmd_rdata;
    end
  end

  dpx_byte_buf #(.NB(MAX_LEN), .IW(LEN_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .wr_en   (buf_we),
    .wr_idx  (idx_q),
    .wr_byte (buf_byte),
    .data    (rep_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
      code_q  <= REP_ACK;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cmd_q   <= req_cmd;
            addr_q  <= req_addr;
            len_q   <= req_len;
            wdata_q <= req_wdata;
            idx_q   <= '0;
            st      <= ST_DISPATCH;
          end
        end
        ST_DISPATCH: begin
          if (ev_bad) begin
            code_q <= REP_AUX_NACK;
            st     <= ST_REPLY;
          end else begin
            case (cls)
              CLS_NATIVE: begin
                if (len_zero) begin
                  code_q <= REP_AUX_NACK;
                  st     <= ST_REPLY;
                end else begin
                  st <= ST_NAT;
                end
              end
              CLS_PLAIN: st <= bus_open ? ST_PRE_STOP : ST_START;
              default: begin
                if (!bus_open)    st <= ST_START;
                else if (differs) st <= ST_PRE_STOP;
                else if (len_zero) begin
                  code_q <= REP_ACK;
                  st     <= ST_REPLY;
                end else st <= ST_XFER;
              end
            endcase
          end
        end
        ST_NAT: begin
          if (reg_done) begin
            if (reg_err) begin
              code_q <= REP_AUX_NACK;
              st     <= ST_REPLY;
            end else if (byte_last) begin
              code_q <= REP_ACK;
              st     <= ST_REPLY;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PRE_STOP: begin
          if (i2c_cmd_done) st <= ST_START;
        end
        ST_START: begin
          if (i2c_cmd_done) begin
            if (i2c_cmd_nack) begin
              code_q <= REP_I2C_NACK;
              st     <= ST_REPLY;
            end else if (len_zero) begin
              code_q <= REP_ACK;
              st     <= is_mot ? ST_REPLY : ST_POST_STOP;
            end else begin
              st <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (i2c_cmd_done) begin
            if (i2c_cmd_nack) begin
              code_q <= REP_I2C_NACK;
              st     <= ST_POST_STOP;
            end else if (byte_last) begin
              code_q <= REP_ACK;
              st     <= is_mot ? ST_REPLY : ST_POST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_POST_STOP: begin
          if (i2c_cmd_done) st <= ST_REPLY;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (st == ST_IDLE);
    rep_valid = (st == ST_REPLY);
    rep_code  = code_q;

    reg_req   = (st == ST_NAT);
    reg_we    = !is_rd;
    reg_addr  = step_addr(addr_q, idx_q);
    reg_wdata = pick_byte(wdata_q, idx_q);

    i2c_cmd_valid = (st == ST_PRE_STOP) || (st == ST_START) ||
                    (st == ST_XFER) || (st == ST_POST_STOP);
    case (st)
      ST_START: i2c_cmd_op = OP_START;
      ST_XFER:  i2c_cmd_op = OP_XFER;
      default:  i2c_cmd_op = OP_STOP;
    endcase
    i2c_cmd_addr  = addr_q[I2C_AW-1:0];
    i2c_cmd_rd    = is_rd;
    i2c_cmd_wdata = pick_byte(wdata_q, idx_q);
  end

endmodule

// File: rtl/dpx_xact_seq_chk.sv
module dpx_xact_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rep_valid,
  input logic [1:0]        rep_code,
  input logic              reg_req,
  input logic              reg_done,
  input logic              reg_err,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              i2c_cmd_valid,
  input logic [1:0]        i2c_cmd_op,
  input logic              i2c_cmd_done,
  input logic              i2c_cmd_nack,
  input logic              ev_bad,
  input logic              byte_last,
  input logic              bus_open
);
  AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> !rep_valid); // R13
  AST_NOT_READY_AT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !req_ready); // R13
  AST_BAD_CMD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (rep_valid && rep_code == 2'b01)); // R2
  AST_NATIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && !reg_err && !byte_last)
      |=> (reg_req && reg_addr == $past(reg_addr) + ADDR_W'(1))); // R3
  AST_NATIVE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && reg_err)
      |=> (!reg_req && rep_valid && rep_code == 2'b01)); // R4
  AST_ONE_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && i2c_cmd_valid)); // R3
  AST_START_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_cmd_valid && i2c_cmd_op == 2'd0) |-> !bus_open); // R11
  AST_START_OPENS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_cmd_valid && i2c_cmd_op == 2'd0 && i2c_cmd_done && !i2c_cmd_nack)
      |=> bus_open); // R9
endmodule

bind dpx_xact_seq dpx_xact_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rep_valid     (rep_valid),
  .rep_code      (rep_code),
  .reg_req       (reg_req),
  .reg_done      (reg_done),
  .reg_err       (reg_err),
  .reg_addr      (reg_addr),
  .i2c_cmd_valid (i2c_cmd_valid),
  .i2c_cmd_op    (i2c_cmd_op),
  .i2c_cmd_done  (i2c_cmd_done),
  .i2c_cmd_nack  (i2c_cmd_nack),
  .ev_bad        (ev_bad),
  .byte_last     (byte_last),
  .bus_open      (bus_open)
);

// File: tb/dpx_xact_seq_bench.sv
`timescale 1ns/1ps
module dpx_xact_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         rep_valid;
  logic [1:0]   rep_code;
  logic [127:0] rep_rdata;
  logic         reg_req, reg_we;
  logic [19:0]  reg_addr;
  logic [7:0]   reg_wdata;
  logic         reg_done = 1'b0, reg_err = 1'b0;
  logic [7:0]   reg_rdata = '0;
  logic         i2c_cmd_valid, i2c_cmd_rd;
  logic [1:0]   i2c_cmd_op;
  logic [6:0]   i2c_cmd_addr;
  logic [7:0]   i2c_cmd_wdata;
  logic         i2c_cmd_done = 1'b0, i2c_cmd_nack = 1'b0;
  logic [7:0]   i2c_cmd_rdata = '0;

  dpx_xact_seq u_dpx_xact_seq (.*);

  // Target models
  logic [7:0] mem [256];
  logic [19:0] reg_log [64];
  logic [1:0]  op_log [256];
  int n_reg = 0, n_start = 0, n_stop = 0, n_xfer = 0, n_ops = 0;
  int fail_at = -1;

  always @(posedge clk) begin
    reg_done     <= 1'b0;
    reg_err      <= 1'b0;
    i2c_cmd_done <= 1'b0;
    i2c_cmd_nack <= 1'b0;
    if (rst_n && reg_req && !reg_done) begin
      reg_done <= 1'b1;
      reg_log[n_reg % 64] <= reg_addr;
      n_reg <= n_reg + 1;
      if (reg_addr[19:8] == 12'hBAD) reg_err <= 1'b1;
      else if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
      else reg_rdata <= mem[reg_addr[7:0]];
    end
    if (rst_n && i2c_cmd_valid && !i2c_cmd_done) begin
      i2c_cmd_done <= 1'b1;
      op_log[n_ops % 256] <= i2c_cmd_op;
      n_ops <= n_ops + 1;
      case (i2c_cmd_op)
        2'd0: begin
          n_start <= n_start + 1;
          i2c_cmd_nack <= !(i2c_cmd_addr == 7'h50 || i2c_cmd_addr == 7'h51);
        end
        2'd1: begin
          n_xfer <= n_xfer + 1;
          i2c_cmd_nack  <= (n_xfer == fail_at);
          i2c_cmd_rdata <= 8'hC0 + 8'(n_xfer);
        end
        default: n_stop <= n_stop + 1;
      endcase
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [1:0]   got_code;
  logic [127:0] got_data;
  int b_reg, b_start, b_stop, b_xfer, b_ops;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    b_reg = n_reg; b_start = n_start; b_stop = n_stop; b_xfer = n_xfer; b_ops = n_ops;
  endtask

  task automatic send(input logic [3:0] c, input logic [19:0] a, input int n,
                      input logic [127:0] wd);
    int guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    snap();
    req_cmd = c; req_addr = a; req_len = 5'(n); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rep_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got_code = rep_code;
    got_data = rep_rdata;
    chk(rep_valid && !req_ready, "R13 reply present with ready low", {rep_valid, req_ready}, 2'b10);
    @(negedge clk);
    chk(!rep_valid, "R13 reply single cycle", rep_valid, 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !rep_valid && !reg_req && !i2c_cmd_valid, "R1 reset state",
        {req_ready, rep_valid, reg_req, i2c_cmd_valid}, 4'b1000);
  endtask

  task automatic t_bad_cmd();
    send(4'h2, 20'h00050, 1, '0);
    chk(got_code == 2'b01, "R2 code 2 reply", got_code, 2'b01);
    chk(n_reg == b_reg && n_ops == b_ops, "R2 code 2 no activity", n_reg + n_ops, b_reg + b_ops);
    send(4'hC, 20'h00010, 2, '0);
    chk(got_code == 2'b01 && n_reg == b_reg, "R2 code C", got_code, 2'b01);
    send(4'h8, 20'h00010, 17, '0);
    chk(got_code == 2'b01 && n_reg == b_reg, "R2 length 17", got_code, 2'b01);
  endtask

  task automatic t_native();
    send(4'h8, 20'h00010, 4, 128'h44_33_22_11);
    chk(got_code == 2'b00, "R3 native write reply", got_code, 0);
    chk(n_reg - b_reg == 4, "R3 write access count", n_reg - b_reg, 4);
    chk(reg_log[b_reg % 64] == 20'h00010 && reg_log[(b_reg + 3) % 64] == 20'h00013,
        "R3 write addresses", reg_log[(b_reg + 3) % 64], 20'h00013);
    send(4'h9, 20'h00011, 3, '0);
    chk(got_code == 2'b00, "R3 native read reply", got_code, 0);
    chk(got_data == 128'h44_33_22, "R3 read lanes", got_data, 128'h44_33_22);
  endtask

  task automatic t_native_err();
    send(4'h9, 20'hBACFE, 4, '0);
    chk(got_code == 2'b01, "R4 error reply", got_code, 2'b01);
    chk(n_reg - b_reg == 3, "R4 stop after failing byte", n_reg - b_reg, 3);
    send(4'h8, 20'h00020, 0, '0);
    chk(got_code == 2'b01, "R5 zero length reply", got_code, 2'b01);
    chk(n_reg == b_reg, "R5 no access", n_reg - b_reg, 0);
  endtask

  task automatic t_mot_idle();
    send(4'h4, 20'h00033, 1, '0);
    chk(got_code == 2'b10, "R9 start refused", got_code, 2'b10);
    chk(n_start - b_start == 1 && n_stop == b_stop && n_xfer == b_xfer, "R9 only a start",
        n_ops - b_ops, 1);
    send(4'h4, 20'h00050, 0, '0);
    chk(got_code == 2'b00, "R12 address-only reply", got_code, 0);
    chk(n_ops - b_ops == 1 && op_log[b_ops % 256] == 2'd0, "R9 bus stayed idle, no stop",
        n_ops - b_ops, 1);
  endtask

  task automatic t_mot_continue();
    send(4'h4, 20'h00050, 2, 128'hBB_AA);
    chk(got_code == 2'b00, "R10 continue reply", got_code, 0);
    chk(n_start == b_start && n_stop == b_stop && n_xfer - b_xfer == 2,
        "R10 no start, two bytes", n_ops - b_ops, 2);
  endtask

  task automatic t_mot_change();
    send(4'h5, 20'h00050, 2, '0);
    chk(n_stop - b_stop == 1 && n_start - b_start == 1, "R11 command change restart",
        n_ops - b_ops, 4);
    chk(op_log[b_ops % 256] == 2'd2 && op_log[(b_ops + 1) % 256] == 2'd0,
        "R11 stop before start", op_log[b_ops % 256], 2'd2);
    chk(got_data[15:0] == {8'hC0 + 8'(b_xfer + 1), 8'hC0 + 8'(b_xfer)},
        "R11 read bytes", got_data[15:0], {8'hC0 + 8'(b_xfer + 1), 8'hC0 + 8'(b_xfer)});
    send(4'h5, 20'h00051, 1, '0);
    chk(got_code == 2'b00 && n_stop - b_stop == 1 && n_start - b_start == 1,
        "R11 address change restart", n_ops - b_ops, 3);
  endtask

  task automatic t_plain();
    send(4'h0, 20'h00050, 3, 128'h03_02_01);
    chk(got_code == 2'b00, "R6 plain reply", got_code, 0);
    chk(n_stop - b_stop == 2 && n_start - b_start == 1 && n_xfer - b_xfer == 3,
        "R6 close, start, bytes, stop", n_ops - b_ops, 6);
    chk(op_log[b_ops % 256] == 2'd2 && op_log[(b_ops + 5) % 256] == 2'd2,
        "R6 stop at both ends", op_log[(b_ops + 5) % 256], 2'd2);
    send(4'h1, 20'h00022, 2, '0);
    chk(got_code == 2'b10, "R7 address refused", got_code, 2'b10);
    chk(n_ops - b_ops == 1, "R7 no byte, no stop", n_ops - b_ops, 1);
  endtask

  task automatic t_byte_fail();
    fail_at = n_xfer + 1;
    send(4'h0, 20'h00050, 4, 128'h04_03_02_01);
    chk(got_code == 2'b10, "R8 byte failure reply", got_code, 2'b10);
    chk(n_xfer - b_xfer == 2 && n_stop - b_stop == 1, "R8 stop after failed byte",
        n_xfer - b_xfer, 2);
    fail_at = n_xfer;
    send(4'h4, 20'h00050, 3, 128'h07_06_05);
    chk(got_code == 2'b10, "R12 MOT byte failure reply", got_code, 2'b10);
    chk(n_start - b_start == 1 && n_xfer - b_xfer == 1 && n_stop - b_stop == 1,
        "R12 MOT stop after failure", n_ops - b_ops, 3);
    fail_at = -1;
    send(4'h4, 20'h00050, 1, 128'h08);
    chk(n_start - b_start == 1 && n_stop == b_stop, "R12 bus closed after failure",
        n_start - b_start, 1);
  endtask

  int cycles = 0;
  bit done = 1'b0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_cmd();
    t_native();
    t_native_err();
    t_mot_idle();
    t_mot_continue();
    t_mot_change();
    t_plain();
    t_byte_fail();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule